// File: doc/BRIEF.md
# Serial TDM Frame Channel Demultiplexer

This block sits between a 20-slot serial time-division line and five internal channel consumers. A one-cycle sync pulse on the line clock starts a frame. The next 20 clock periods each carry one bit. The block splits those bits into two 8-bit bearer streams, a 2-bit signaling field, a single maintenance bit and a single auxiliary bit. Each of these has its own parallel output and a one-cycle valid strobe. In the other direction it takes parallel data for the same five channels and puts it onto the line. The line driver is enabled only in the slots of channels that are switched on.

A per-channel enable vector decides which channels take part. A join control combines the two bearer slots into one 16-bit stream, delivered with a single strobe. The transmit data changes just after the rising clock edge. Receive data is captured on the falling edge, half a period later. The transmit pin is a data bit plus an enable, so that a pad buffer can release the line outside active slots.

Top module: `tdm_frame_chan`

## Requirements
- R1: A high `sync_i` at a rising edge starts a frame. That edge and the 19 that follow each begin one slot, numbered 0 to 19. After slot 19 the block is idle until the next sync.
- R2: Slot map: bearer A uses slots 0–7, signaling uses slots 8 and 18, maintenance uses slot 9, bearer B uses slots 10–17 and auxiliary uses slot 19. Within a bearer, the earliest slot carries the most significant bit. The slot-8 bit is signaling bit 1 and the slot-18 bit is signaling bit 0. Enable bits: [0] bearer A, [1] bearer B, [2] signaling, [3] maintenance, [4] auxiliary.
- R3: Receive bits are taken only inside a frame. Line activity while idle produces no strobe.
- R4: `txd_oe_o` is high only during slots of enabled channels. It is low while idle. In join mode, bearer B slots follow enable bit [0].
- R5: During an enabled slot, `txd_o` carries that slot's bit. The bits come from the transmit inputs as they were at the sync edge, and later changes to those inputs do not affect the running frame.
- R6: With join off, each enabled bearer pulses its valid for one cycle, beginning at the rising edge that ends its last slot (slot 7 for A, slot 17 for B).
- R7: With join on, the two separate bearer strobes stay low. `bj_rx_vld_o` pulses after slot 17 when enable bit [0] is set, with bearer A in bits 15:8 and bearer B in bits 7:0.
- R8: When enabled, signaling delivers its 2-bit value with one strobe per frame, after slot 18.
- R9: Maintenance and auxiliary each have their own bit output and strobe, pulsing after slots 9 and 19 when enabled. No two strobes are ever high in the same cycle.
- R10: A sync that arrives before slot 19 ends drops the partial frame and restarts at slot 0. Channels that had not finished produce no strobe for the dropped frame.
- R11: While reset is asserted, all strobes and `txd_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame start pulse, sampled on rising edge |
| rxd_i | input | 1 | Serial receive data, sampled on falling edge |
| txd_o | output | 1 | Serial transmit data |
| txd_oe_o | output | 1 | Transmit pad enable |
| ch_en_i | input | 5 | Per-channel enable vector |
| join_i | input | 1 | Combine bearers into one 16-bit stream |
| ba_tx_i | input | 8 | Bearer A transmit byte |
| bb_tx_i | input | 8 | Bearer B transmit byte |
| sig_tx_i | input | 2 | Signaling transmit bits |
| mnt_tx_i | input | 1 | Maintenance transmit bit |
| aux_tx_i | input | 1 | Auxiliary transmit bit |
| ba_rx_o | output | 8 | Bearer A received byte |
| ba_rx_vld_o | output | 1 | Bearer A strobe |
| bb_rx_o | output | 8 | Bearer B received byte |
| bb_rx_vld_o | output | 1 | Bearer B strobe |
| bj_rx_o | output | 16 | Joined bearer word |
| bj_rx_vld_o | output | 1 | Joined bearer strobe |
| sig_rx_o | output | 2 | Signaling received bits |
| sig_rx_vld_o | output | 1 | Signaling strobe |
| mnt_rx_o | output | 1 | Maintenance received bit |
| mnt_rx_vld_o | output | 1 | Maintenance strobe |
| aux_rx_o | output | 1 | Auxiliary received bit |
| aux_rx_vld_o | output | 1 | Auxiliary strobe |

## Verification
A slot counter that is off by one shows within one bit period in two ways. `txd_oe_o` rises or falls one slot early or late, and a strobe appears in a neighbouring cycle, sometimes with a bit pulled from the wrong channel. A lost or wrong falling-edge capture corrupts exactly one bit of one channel's parallel value. This shows at that channel's next strobe, no more than 20 cycles later. A stale transmit hold register, or a restart that does not clear on an early sync, shows as wrong `txd_o` bits or extra strobes within the same or the following frame.

// File: rtl/tdm_frame_pkg.sv
package tdm_frame_pkg;
  localparam int FRAME_BITS = 20;
  localparam int SLOT_W     = $clog2(FRAME_BITS);
  localparam int BEAR_W     = 8;
  localparam int SIG_W      = 2;
  localparam int NUM_CH     = 5;
  localparam int JOIN_W     = 2 * BEAR_W;

  localparam int BA_FIRST = 0;
  localparam int SIG_HI   = BA_FIRST + BEAR_W;
  localparam int MNT_SLOT = SIG_HI + 1;
  localparam int BB_FIRST = MNT_SLOT + 1;
  localparam int SIG_LO   = BB_FIRST + BEAR_W;
  localparam int AUX_SLOT = SIG_LO + 1;
  localparam int BA_LAST  = BA_FIRST + BEAR_W - 1;
  localparam int BB_LAST  = BB_FIRST + BEAR_W - 1;
  localparam int LAST_SLOT = FRAME_BITS - 1;

  typedef enum logic [2:0] {
    CH_BA  = 3'd0,
    CH_BB  = 3'd1,
    CH_SIG = 3'd2,
    CH_MNT = 3'd3,
    CH_AUX = 3'd4
  } chan_e;

  function automatic chan_e slot_chan(input logic [SLOT_W-1:0] s);
    int v;
    v = int'(s);
    if (v <= BA_LAST)        return CH_BA;
    else if (v == SIG_HI)    return CH_SIG;
    else if (v == MNT_SLOT)  return CH_MNT;
    else if (v <= BB_LAST)   return CH_BB;
    else if (v == SIG_LO)    return CH_SIG;
    else                     return CH_AUX;
  endfunction

  function automatic logic slot_enabled(input logic [SLOT_W-1:0] s,
                                        input logic [NUM_CH-1:0] en,
                                        input logic              join_bearers);
    chan_e c;
    c = slot_chan(s);
    if (c == CH_BB && join_bearers) return en[int'(CH_BA)];
    return en[int'(c)];
  endfunction
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
  import tdm_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  output logic              active_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic              act_q, act_n;
  logic [SLOT_W-1:0] slot_q, slot_n;

  always_comb begin
    act_n  = act_q;
    slot_n = slot_q;
    if (sync_i) begin
      act_n  = 1'b1;
      slot_n = '0;
    end else if (act_q) begin
      if (slot_q == SLOT_W'(LAST_SLOT)) begin
        act_n  = 1'b0;
        slot_n = '0;
      end else begin
        slot_n = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      act_q  <= act_n;
      slot_q <= slot_n;
    end
  end

  assign active_o = act_q;
  assign slot_o   = slot_q;

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> slot_q <= SLOT_W'(LAST_SLOT)); // R1
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && slot_q == SLOT_W'(LAST_SLOT) && !sync_i) |=> !act_q); // R1
  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (act_q && slot_q == '0)); // R10
endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture
  import tdm_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              rxd_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic              join_i,
  output logic [BEAR_W-1:0] ba_o,
  output logic              ba_vld_o,
  output logic [BEAR_W-1:0] bb_o,
  output logic              bb_vld_o,
  output logic [JOIN_W-1:0] bj_o,
  output logic              bj_vld_o,
  output logic [SIG_W-1:0]  sig_o,
  output logic              sig_vld_o,
  output logic              mnt_o,
  output logic              mnt_vld_o,
  output logic              aux_o,
  output logic              aux_vld_o
);
  // falling-edge sampler: bit, its slot and whether it lies in a frame
  logic              smp_bit_q, smp_live_q, smp_live_n;
  logic [SLOT_W-1:0] smp_slot_q;

  assign smp_live_n = active_i;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_bit_q  <= 1'b0;
      smp_live_q <= 1'b0;
      smp_slot_q <= '0;
    end else begin
      smp_bit_q  <= rxd_i;
      smp_live_q <= smp_live_n;
      smp_slot_q <= slot_i;
    end
  end

  // rising-edge consumer: frame register and strobes
  logic [FRAME_BITS-1:0] frame_q, frame_n;
  logic [5:0]            stb_q, stb_n;

  always_comb begin
    frame_n = frame_q;
    if (smp_live_q) frame_n[smp_slot_q] = smp_bit_q;
    stb_n[0] = smp_live_q && smp_slot_q == SLOT_W'(BA_LAST)  && ch_en_i[int'(CH_BA)] && !join_i;
    stb_n[1] = smp_live_q && smp_slot_q == SLOT_W'(BB_LAST)  && ch_en_i[int'(CH_BB)] && !join_i;
    stb_n[2] = smp_live_q && smp_slot_q == SLOT_W'(BB_LAST)  && ch_en_i[int'(CH_BA)] && join_i;
    stb_n[3] = smp_live_q && smp_slot_q == SLOT_W'(SIG_LO)   && ch_en_i[int'(CH_SIG)];
    stb_n[4] = smp_live_q && smp_slot_q == SLOT_W'(MNT_SLOT) && ch_en_i[int'(CH_MNT)];
    stb_n[5] = smp_live_q && smp_slot_q == SLOT_W'(AUX_SLOT) && ch_en_i[int'(CH_AUX)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      stb_q   <= '0;
    end else begin
      frame_q <= frame_n;
      stb_q   <= stb_n;
    end
  end

  for (genvar i = 0; i < BEAR_W; i++) begin : g_bear
    assign ba_o[BEAR_W-1-i] = frame_q[BA_FIRST+i];
    assign bb_o[BEAR_W-1-i] = frame_q[BB_FIRST+i];
  end

  assign bj_o      = {ba_o, bb_o};
  assign sig_o     = {frame_q[SIG_HI], frame_q[SIG_LO]};
  assign mnt_o     = frame_q[MNT_SLOT];
  assign aux_o     = frame_q[AUX_SLOT];
  assign ba_vld_o  = stb_q[0];
  assign bb_vld_o  = stb_q[1];
  assign bj_vld_o  = stb_q[2];
  assign sig_vld_o = stb_q[3];
  assign mnt_vld_o = stb_q[4];
  assign aux_vld_o = stb_q[5];

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ba_vld_o, bb_vld_o, bj_vld_o, sig_vld_o, mnt_vld_o, aux_vld_o})); // R9
  AST_JOIN_SPLIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    join_i |=> (!ba_vld_o && !bb_vld_o)); // R7
  AST_STB_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb_q) |-> $past(active_i)); // R3
endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
  import tdm_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              active_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic              join_i,
  input  logic [BEAR_W-1:0] ba_i,
  input  logic [BEAR_W-1:0] bb_i,
  input  logic [SIG_W-1:0]  sig_i,
  input  logic              mnt_i,
  input  logic              aux_i,
  output logic              txd_o,
  output logic              txd_oe_o
);
  logic [FRAME_BITS-1:0] hold_q, hold_n, load_vec;

  for (genvar i = 0; i < BEAR_W; i++) begin : g_map
    assign load_vec[BA_FIRST+i] = ba_i[BEAR_W-1-i];
    assign load_vec[BB_FIRST+i] = bb_i[BEAR_W-1-i];
  end
  assign load_vec[SIG_HI]   = sig_i[1];
  assign load_vec[SIG_LO]   = sig_i[0];
  assign load_vec[MNT_SLOT] = mnt_i;
  assign load_vec[AUX_SLOT] = aux_i;

  always_comb begin
    hold_n = hold_q;
    if (sync_i) hold_n = load_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_n;
  end

  assign txd_oe_o = active_i && slot_enabled(slot_i, ch_en_i, join_i);
  assign txd_o    = txd_oe_o ? hold_q[slot_i] : 1'b0;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !sync_i) |=> $stable(hold_q)); // R5
  AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    txd_oe_o |-> active_i); // R4
endmodule

// File: rtl/tdm_frame_chan.sv
module tdm_frame_chan
  import tdm_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              txd_oe_o,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic              join_i,
  input  logic [BEAR_W-1:0] ba_tx_i,
  input  logic [BEAR_W-1:0] bb_tx_i,
  input  logic [SIG_W-1:0]  sig_tx_i,
  input  logic              mnt_tx_i,
  input  logic              aux_tx_i,
  output logic [BEAR_W-1:0] ba_rx_o,
  output logic              ba_rx_vld_o,
  output logic [BEAR_W-1:0] bb_rx_o,
  output logic              bb_rx_vld_o,
  output logic [JOIN_W-1:0] bj_rx_o,
  output logic              bj_rx_vld_o,
  output logic [SIG_W-1:0]  sig_rx_o,
  output logic              sig_rx_vld_o,
  output logic              mnt_rx_o,
  output logic              mnt_rx_vld_o,
  output logic              aux_rx_o,
  output logic              aux_rx_vld_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic              active;
  logic [SLOT_W-1:0] slot;

  tdm_slot_timer i_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sync_i   (sync_i),
    .active_o (active),
    .slot_o   (slot)
  );

  tdm_rx_capture i_rx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .active_i  (active),
    .slot_i    (slot),
    .rxd_i     (rxd_i),
    .ch_en_i   (ch_en_i),
    .join_i    (join_i),
    .ba_o      (ba_rx_o),
    .ba_vld_o  (ba_rx_vld_o),
    .bb_o      (bb_rx_o),
    .bb_vld_o  (bb_rx_vld_o),
    .bj_o      (bj_rx_o),
    .bj_vld_o  (bj_rx_vld_o),
    .sig_o     (sig_rx_o),
    .sig_vld_o (sig_rx_vld_o),
    .mnt_o     (mnt_rx_o),
    .mnt_vld_o (mnt_rx_vld_o),
    .aux_o     (aux_rx_o),
    .aux_vld_o (aux_rx_vld_o)
  );

  tdm_tx_serializer i_tx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sync_i   (sync_i),
    .active_i (active),
    .slot_i   (slot),
    .ch_en_i  (ch_en_i),
    .join_i   (join_i),
    .ba_i     (ba_tx_i),
    .bb_i     (bb_tx_i),
    .sig_i    (sig_tx_i),
    .mnt_i    (mnt_tx_i),
    .aux_i    (aux_tx_i),
    .txd_o    (txd_o),
    .txd_oe_o (txd_oe_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_core_n |-> (!txd_oe_o && !ba_rx_vld_o && !bb_rx_vld_o && !bj_rx_vld_o
                     && !sig_rx_vld_o && !mnt_rx_vld_o && !aux_rx_vld_o)); // R11
endmodule

// File: tb/test_tdm_frame_chan.sv
module test_tdm_frame_chan;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, sync_i, rxd_i, txd_o, txd_oe_o, join_i;
  logic [4:0]  ch_en_i;
  logic [7:0]  ba_tx_i, bb_tx_i, ba_rx_o, bb_rx_o;
  logic [1:0]  sig_tx_i, sig_rx_o;
  logic        mnt_tx_i, aux_tx_i, mnt_rx_o, aux_rx_o;
  logic [15:0] bj_rx_o;
  logic        ba_rx_vld_o, bb_rx_vld_o, bj_rx_vld_o, sig_rx_vld_o, mnt_rx_vld_o, aux_rx_vld_o;

  tdm_frame_chan i_tdm_frame_chan (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .rxd_i(rxd_i),
    .txd_o(txd_o), .txd_oe_o(txd_oe_o), .ch_en_i(ch_en_i), .join_i(join_i),
    .ba_tx_i(ba_tx_i), .bb_tx_i(bb_tx_i), .sig_tx_i(sig_tx_i),
    .mnt_tx_i(mnt_tx_i), .aux_tx_i(aux_tx_i),
    .ba_rx_o(ba_rx_o), .ba_rx_vld_o(ba_rx_vld_o), .bb_rx_o(bb_rx_o), .bb_rx_vld_o(bb_rx_vld_o),
    .bj_rx_o(bj_rx_o), .bj_rx_vld_o(bj_rx_vld_o), .sig_rx_o(sig_rx_o), .sig_rx_vld_o(sig_rx_vld_o),
    .mnt_rx_o(mnt_rx_o), .mnt_rx_vld_o(mnt_rx_vld_o), .aux_rx_o(aux_rx_o), .aux_rx_vld_o(aux_rx_vld_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // R2 slot map: returns enable index of the slot's channel
  function automatic int slot_ch(input int s);
    if (s <= 7)       return 0;
    else if (s == 8)  return 2;
    else if (s == 9)  return 3;
    else if (s <= 17) return 1;
    else if (s == 18) return 2;
    else              return 4;
  endfunction

  function automatic bit slot_en(input int s, input logic [4:0] en, input bit j);
    int c;
    c = slot_ch(s);
    if (c == 1 && j) return en[0];
    return en[c];
  endfunction

  function automatic bit tx_bit(input int s, input logic [7:0] a, input logic [7:0] b,
                                input logic [1:0] g, input logic m, input logic x);
    if (s <= 7)       return a[7-s];
    else if (s == 8)  return g[1];
    else if (s == 9)  return m;
    else if (s <= 17) return b[17-s];
    else if (s == 18) return g[0];
    else              return x;
  endfunction

  function automatic logic [7:0] byte_at(input logic [19:0] rx, input int first);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[7-i] = rx[first+i];
    return v;
  endfunction

  task automatic check_strobes(input int k, input logic [19:0] rx, input bit j);
    logic [5:0] exp, act;
    exp[0] = (k == 7)  && ch_en_i[0] && !j;
    exp[1] = (k == 17) && ch_en_i[1] && !j;
    exp[2] = (k == 17) && ch_en_i[0] && j;
    exp[3] = (k == 18) && ch_en_i[2];
    exp[4] = (k == 9)  && ch_en_i[3];
    exp[5] = (k == 19) && ch_en_i[4];
    act = {aux_rx_vld_o, mnt_rx_vld_o, sig_rx_vld_o, bj_rx_vld_o, bb_rx_vld_o, ba_rx_vld_o};
    chk(act == exp, "R6 R7 R8 R9 strobes", 32'(act), 32'(exp));
    if (exp[0]) chk(ba_rx_o == byte_at(rx, 0), "R2 R6 bearer A", 32'(ba_rx_o), 32'(byte_at(rx, 0)));
    if (exp[1]) chk(bb_rx_o == byte_at(rx, 10), "R2 R6 bearer B", 32'(bb_rx_o), 32'(byte_at(rx, 10)));
    if (exp[2]) chk(bj_rx_o == {byte_at(rx, 0), byte_at(rx, 10)}, "R7 joined",
                    32'(bj_rx_o), 32'({byte_at(rx, 0), byte_at(rx, 10)}));
    if (exp[3]) chk(sig_rx_o == {rx[8], rx[18]}, "R8 signaling", 32'(sig_rx_o), 32'({rx[8], rx[18]}));
    if (exp[4]) chk(mnt_rx_o == rx[9], "R9 maintenance", 32'(mnt_rx_o), 32'(rx[9]));
    if (exp[5]) chk(aux_rx_o == rx[19], "R9 auxiliary", 32'(aux_rx_o), 32'(rx[19]));
  endtask

  // Sync is raised now and sampled at the next rising edge; nslots < 20 aborts by resync
  task automatic run_frame(input logic [19:0] rx, input logic [39:0] seed, input int nslots,
                           input bit scramble);
    logic [7:0] a, b;
    logic [1:0] g;
    logic m, x;
    bit j;
    a = seed[7:0]; b = seed[15:8]; g = seed[17:16]; m = seed[18]; x = seed[19];
    j = join_i;
    sync_i = 1'b1;
    ba_tx_i = a; bb_tx_i = b; sig_tx_i = g; mnt_tx_i = m; aux_tx_i = x;
    for (int s = 0; s < nslots; s++) begin
      @(posedge clk); #1;
      sync_i = 1'b0;
      rxd_i = rx[s];
      if (scramble && s == 3) begin
        ba_tx_i = ~a; bb_tx_i = ~b; sig_tx_i = ~g; mnt_tx_i = ~m; aux_tx_i = ~x;
      end
      #2;
      chk(txd_oe_o == slot_en(s, ch_en_i, j), "R4 tx enable", 32'(txd_oe_o), 32'(slot_en(s, ch_en_i, j)));
      if (slot_en(s, ch_en_i, j))
        chk(txd_o == tx_bit(s, a, b, g, m, x), "R5 tx bit", 32'(txd_o), 32'(tx_bit(s, a, b, g, m, x)));
      if (s >= 1) check_strobes(s - 1, rx, j);
    end
    if (nslots == 20) begin
      @(posedge clk); #1;
      rxd_i = ~rxd_i;
      #2;
      check_strobes(19, rx, j);
      chk(txd_oe_o == 1'b0, "R1 idle after slot 19", 32'(txd_oe_o), 32'd0);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rxd_i = ~rxd_i;
      #2;
      chk({aux_rx_vld_o, mnt_rx_vld_o, sig_rx_vld_o, bj_rx_vld_o, bb_rx_vld_o, ba_rx_vld_o} == 6'd0,
          "R3 no strobe while idle",
          32'({aux_rx_vld_o, mnt_rx_vld_o, sig_rx_vld_o, bj_rx_vld_o, bb_rx_vld_o, ba_rx_vld_o}), 32'd0);
      chk(txd_oe_o == 1'b0, "R4 idle enable", 32'(txd_oe_o), 32'd0);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] h;
    rst_n = 1'b0; sync_i = 1'b0; rxd_i = 1'b1; ch_en_i = 5'h1f; join_i = 1'b0;
    ba_tx_i = '0; bb_tx_i = '0; sig_tx_i = '0; mnt_tx_i = 1'b0; aux_tx_i = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    chk({txd_oe_o, aux_rx_vld_o, mnt_rx_vld_o, sig_rx_vld_o, bj_rx_vld_o, bb_rx_vld_o, ba_rx_vld_o} == 7'd0,
        "R11 reset state",
        32'({txd_oe_o, aux_rx_vld_o, mnt_rx_vld_o, sig_rx_vld_o, bj_rx_vld_o, bb_rx_vld_o, ba_rx_vld_o}), 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(4);

    // R1 R2 R6 R7 R8 R9: every enable pattern, split and joined
    for (int j = 0; j < 2; j++) begin
      for (int e = 0; e < 32; e++) begin
        join_i = j[0];
        ch_en_i = e[4:0];
        h = (32'(e) + 32'(j) * 32) * 32'h9E3779B1;
        run_frame(h[26:7], {8'h00, h ^ 32'h5A5A_C3C3}, 20, (e % 3) == 0);
        idle(2);
      end
    end

    // R10: early resyncs, split then joined
    join_i = 1'b0; ch_en_i = 5'h1f;
    run_frame(20'hFFFFF, 40'h0_000A_5C3, 5, 1'b0);
    run_frame(20'h3C96A, 40'h0_0005_A3C, 20, 1'b0);
    idle(1);
    run_frame(20'hAAAAA, 40'h0_000F_0F0, 12, 1'b0);
    run_frame(20'h5129E, 40'h0_0003_33C, 20, 1'b0);
    idle(1);
    join_i = 1'b1;
    run_frame(20'h0F0F0, 40'h0_0009_9C6, 15, 1'b0);
    run_frame(20'hC3A51, 40'h0_0006_6A5, 20, 1'b0);
    idle(3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule